// File: doc/BRIEF.md
# Double-Precision Operand Screen

This block checks one 64-bit IEEE double-precision operand on its way into a floating-point arithmetic unit. Each operand is sorted into one of five classes: true zero, denormal, normal, infinity or NaN. Depending on the class, the operand passes through untouched, is reduced to a signed zero, or raises an arithmetic trap with a cause code. The arithmetic itself lies outside the block.

Two controls select the treatment. The first is a flush-to-zero enable for denormal inputs. The second is a 2-bit screening mode: arithmetic, comparison, or deferred screening for software completion. In arithmetic mode every special operand traps. Comparison mode lets infinities through because ordering them is well defined. Deferred mode never traps and leaves exception detection to the operation that follows, so it only applies the flush. The decision is combinational. By default a single register stage follows it, so results appear one clock after the operand is presented.

Top module: `dbl_input_screen`

## Requirements
- R1: The sign is bit 63, the exponent is bits 62:52 and the fraction is bits 51:0. A true zero (exponent 0, fraction 0) or a normal number (exponent neither 0 nor all ones) appears unchanged on `op_out` with no trap in every mode, except as stated in R7.
- R2: In modes 00, 01 and 11, a denormal (exponent 0, fraction nonzero) with `dnz_en`=1 is output as its sign bit in bit 63 with all other bits 0, and it raises no trap.
- R3: In modes 00, 01 and 11, a denormal with `dnz_en`=0 raises a trap with cause code 01 (underflow).
- R4: In mode 00, an infinity (exponent all ones, fraction 0) raises a trap with cause code 11 (overflow).
- R5: In modes 00, 01 and 11, a NaN (exponent all ones, fraction nonzero), whether quiet or signalling, raises a trap with cause code 10 (invalid).
- R6: In mode 01 (comparison), an infinity of either sign passes unchanged with no trap.
- R7: In mode 10 (deferred), no trap is ever raised. With `dnz_en`=1, any operand whose exponent is 0 is output as its sign bit alone. Every other operand passes unchanged.
- R8: While `trap_out` is 1, `op_out` equals the input operand unchanged and `cause_out` is nonzero. While `trap_out` is 0, `cause_out` is 00.
- R9: Mode code 11 gives exactly the results of mode 00.
- R10: With the default output register, results appear on the outputs one clock after the inputs are sampled. During reset the outputs are all zero with no trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| op_in | input | 64 | Operand to screen |
| dnz_en | input | 1 | Flush denormal inputs to signed zero |
| mode_sel | input | 2 | 00 arithmetic, 01 comparison, 10 deferred, 11 as arithmetic |
| op_out | output | 64 | Screened operand |
| trap_out | output | 1 | Arithmetic trap request |
| cause_out | output | 2 | 00 none, 01 underflow, 10 invalid, 11 overflow |

## Verification
A directed sweep applies positive and negative zero, smallest and largest denormals, normals, infinities, and quiet and signalling NaNs. Each is tried in all four modes with the flush enable both off and on. Together these separate the three mode policies and the 11 alias from one another. The smallest and largest denormals and the infinity-versus-NaN pair test the exponent and fraction boundary decisions, and the signed inputs show that a flush keeps the sign. Random operands, weighted towards exponent 0 and all ones, then check the whole mapping against a bench model. Both bit patterns are covered: the fraction-only ones and the exponent-only ones.

// File: rtl/dis_pkg.sv
package dis_pkg;

    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = 52;

    typedef enum logic [1:0] {
        SCR_ARITH = 2'b00,
        SCR_CMP   = 2'b01,
        SCR_DEFER = 2'b10,
        SCR_ALIAS = 2'b11
    } scr_mode_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_UNF  = 2'b01,
        CAUSE_INV  = 2'b10,
        CAUSE_FOV  = 2'b11
    } trap_cause_e;

    typedef enum logic [2:0] {
        CLS_ZERO   = 3'd0,
        CLS_DENORM = 3'd1,
        CLS_NORMAL = 3'd2,
        CLS_INF    = 3'd3,
        CLS_NAN    = 3'd4
    } op_class_e;

    typedef struct packed {
        logic        trap;
        trap_cause_e cause;
    } trap_info_t;

    function automatic op_class_e class_of(input logic exp_zero,
                                           input logic exp_ones,
                                           input logic frac_nz);
        if (exp_zero)      return frac_nz ? CLS_DENORM : CLS_ZERO;
        else if (exp_ones) return frac_nz ? CLS_NAN : CLS_INF;
        else               return CLS_NORMAL;
    endfunction

    function automatic logic traps_on_inf(input scr_mode_e m);
        return (m == SCR_ARITH) || (m == SCR_ALIAS);
    endfunction

endpackage

// File: rtl/dis_classify.sv
module dis_classify
    import dis_pkg::*;
#(
    parameter int EXP_W  = DBL_EXP_W,
    parameter int FRAC_W = DBL_FRAC_W,
    localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
    input  logic [DATA_W-1:0] operand,
    output op_class_e         cls
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = operand[DATA_W-2 -: EXP_W];
    assign frac_f = operand[FRAC_W-1:0];

    always_comb begin
        cls = class_of(~|exp_f, &exp_f, |frac_f);
    end
endmodule

// File: rtl/dis_policy.sv
module dis_policy
    import dis_pkg::*;
#(
    parameter int EXP_W  = DBL_EXP_W,
    parameter int FRAC_W = DBL_FRAC_W,
    localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
    input  logic [DATA_W-1:0] operand,
    input  op_class_e         cls,
    input  scr_mode_e         mode,
    input  logic              dnz,
    output logic [DATA_W-1:0] value,
    output trap_info_t        info
);
    logic [DATA_W-1:0] signed_zero;
    logic              deferred;

    assign signed_zero = {operand[DATA_W-1], {(DATA_W-1){1'b0}}};
    assign deferred    = (mode == SCR_DEFER);

    always_comb begin
        value      = operand;
        info.trap  = 1'b0;
        info.cause = CAUSE_NONE;
        unique case (cls)
            CLS_ZERO: begin
                if (deferred && dnz) value = signed_zero;
            end
            CLS_DENORM: begin
                if (dnz) begin
                    value = signed_zero;
                end else if (!deferred) begin
                    info.trap  = 1'b1;
                    info.cause = CAUSE_UNF;
                end
            end
            CLS_INF: begin
                if (traps_on_inf(mode)) begin
                    info.trap  = 1'b1;
                    info.cause = CAUSE_FOV;
                end
            end
            CLS_NAN: begin
                if (!deferred) begin
                    info.trap  = 1'b1;
                    info.cause = CAUSE_INV;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dis_stage.sv
module dis_stage
    import dis_pkg::*;
#(
    parameter int DATA_W  = 1 + DBL_EXP_W + DBL_FRAC_W,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] d_value,
    input  trap_info_t        d_info,
    output logic [DATA_W-1:0] q_value,
    output trap_info_t        q_info
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_value     <= '0;
                    q_info.trap <= 1'b0;
                    q_info.cause <= CAUSE_NONE;
                end else begin
                    q_value <= d_value;
                    q_info  <= d_info;
                end
            end
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst;
            assign q_value = d_value;
            assign q_info  = d_info;
        end
    endgenerate
endmodule

// File: rtl/dbl_input_screen.sv
module dbl_input_screen
    import dis_pkg::*;
#(
    parameter int EXP_W   = DBL_EXP_W,
    parameter int FRAC_W  = DBL_FRAC_W,
    parameter bit REG_OUT = 1'b1,
    localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] op_in,
    input  logic              dnz_en,
    input  logic [1:0]        mode_sel,
    output logic [DATA_W-1:0] op_out,
    output logic              trap_out,
    output logic [1:0]        cause_out
);
    op_class_e         cls;
    logic [DATA_W-1:0] scr_value;
    trap_info_t        scr_info;
    logic [DATA_W-1:0] q_value;
    trap_info_t        q_info;

    dis_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
        .operand (op_in),
        .cls     (cls)
    );

    dis_policy #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_policy (
        .operand (op_in),
        .cls     (cls),
        .mode    (scr_mode_e'(mode_sel)),
        .dnz     (dnz_en),
        .value   (scr_value),
        .info    (scr_info)
    );

    dis_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .d_value (scr_value),
        .d_info  (scr_info),
        .q_value (q_value),
        .q_info  (q_info)
    );

    assign op_out    = q_value;
    assign trap_out  = q_info.trap;
    assign cause_out = q_info.cause;
endmodule

// File: rtl/dis_checker.sv
module dis_checker #(
    parameter int EXP_W   = 11,
    parameter int FRAC_W  = 52,
    parameter bit REG_OUT = 1'b1,
    localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] op_in,
    input logic              dnz_en,
    input logic [1:0]        mode_sel,
    input logic [DATA_W-1:0] op_out,
    input logic              trap_out,
    input logic [1:0]        cause_out
);
    logic [DATA_W-1:0] c_op;
    logic              c_dnz;
    logic [1:0]        c_mode;
    logic              seen;

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    generate
        if (REG_OUT) begin : g_lag
            always_ff @(posedge clk) begin
                c_op   <= op_in;
                c_dnz  <= dnz_en;
                c_mode <= mode_sel;
            end
        end else begin : g_now
            assign c_op   = op_in;
            assign c_dnz  = dnz_en;
            assign c_mode = mode_sel;
        end
    endgenerate

    logic c_ezero, c_eones, c_fnz;
    assign c_ezero = ~|c_op[DATA_W-2 -: EXP_W];
    assign c_eones = &c_op[DATA_W-2 -: EXP_W];
    assign c_fnz   = |c_op[FRAC_W-1:0];

    assert_cause_pairing_R8: assert property (@(posedge clk) disable iff (rst || !seen)
        trap_out == (cause_out != 2'b00));

    assert_trap_keeps_operand_R8: assert property (@(posedge clk) disable iff (rst || !seen)
        trap_out |-> (op_out == c_op));

    assert_deferred_no_trap_R7: assert property (@(posedge clk) disable iff (rst || !seen)
        (c_mode == 2'b10) |-> !trap_out);

    assert_cmp_inf_pass_R6: assert property (@(posedge clk) disable iff (rst || !seen)
        (c_mode == 2'b01 && c_eones && !c_fnz) |-> (!trap_out && op_out == c_op));

    assert_denorm_flush_R2: assert property (@(posedge clk) disable iff (rst || !seen)
        (c_dnz && c_ezero && c_fnz) |->
            (!trap_out && op_out == {c_op[DATA_W-1], {(DATA_W-1){1'b0}}}));

    assert_inf_overflow_R4: assert property (@(posedge clk) disable iff (rst || !seen)
        (c_mode[0] == c_mode[1] && c_eones && !c_fnz) |-> (trap_out && cause_out == 2'b11));

    assert_nan_invalid_R5: assert property (@(posedge clk) disable iff (rst || !seen)
        (c_mode != 2'b10 && c_eones && c_fnz) |-> (trap_out && cause_out == 2'b10));
endmodule

bind dbl_input_screen dis_checker #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .REG_OUT(REG_OUT)
) u_dis_checker (
    .clk(clk), .rst(rst), .op_in(op_in), .dnz_en(dnz_en), .mode_sel(mode_sel),
    .op_out(op_out), .trap_out(trap_out), .cause_out(cause_out)
);

// File: tb/dbl_input_screen_bench.sv
module dbl_input_screen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] op_in = '0;
    logic        dnz_en = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic [63:0] op_out;
    logic        trap_out;
    logic [1:0]  cause_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    dbl_input_screen u_dbl_input_screen (
        .clk(clk), .rst(rst), .op_in(op_in), .dnz_en(dnz_en), .mode_sel(mode_sel),
        .op_out(op_out), .trap_out(trap_out), .cause_out(cause_out)
    );

    // expected {value, trap, cause}
    function automatic logic [66:0] model(input logic [63:0] op, input logic dnz,
                                          input logic [1:0] mode);
        logic [10:0] e;
        logic        fnz;
        logic [63:0] v;
        logic        t;
        logic [1:0]  c;
        e = op[62:52];
        fnz = |op[51:0];
        v = op; t = 0; c = 2'b00;
        if (mode == 2'b10) begin
            if (dnz && e == 0) v = {op[63], 63'd0};        // R7
        end else if (e == 0 && fnz) begin
            if (dnz) v = {op[63], 63'd0};                  // R2
            else begin t = 1; c = 2'b01; end               // R3
        end else if (e == 11'h7ff) begin
            if (fnz) begin t = 1; c = 2'b10; end           // R5
            else if (mode != 2'b01) begin t = 1; c = 2'b11; end // R4, R9; R6 passes
        end
        return {v, t, c};
    endfunction

    function automatic string req_of(input logic [63:0] op, input logic dnz,
                                     input logic [1:0] mode);
        logic [10:0] e;
        e = op[62:52];
        if (mode == 2'b10) return "R7";
        if (mode == 2'b11) return "R9";
        if (e == 0 && |op[51:0]) return dnz ? "R2" : "R3";
        if (e == 11'h7ff) begin
            if (|op[51:0]) return "R5";
            return (mode == 2'b01) ? "R6" : "R4";
        end
        return "R1";
    endfunction

    task automatic apply(input logic [63:0] op, input logic dnz, input logic [1:0] mode);
        logic [66:0] exp_v;
        string tag;
        @(negedge clk);
        op_in = op; dnz_en = dnz; mode_sel = mode;
        exp_v = model(op, dnz, mode);
        tag = req_of(op, dnz, mode);
        @(negedge clk);   // one register: result visible after the edge in between (R10)
        n_tests++;
        if ({op_out, trap_out, cause_out} !== exp_v) begin
            n_fail++;
            $display("FAIL %s op=%h dnz=%0d mode=%0d got v=%h t=%0d c=%0d exp v=%h t=%0d c=%0d",
                     tag, op, dnz, mode, op_out, trap_out, cause_out,
                     exp_v[66:3], exp_v[2], exp_v[1:0]);
        end
        n_tests++;
        if (trap_out && (op_out !== op || cause_out == 2'b00)) begin // R8
            n_fail++;
            $display("FAIL R8 op=%h got v=%h c=%0d exp v=%h c!=0", op, op_out, cause_out, op);
        end
    endtask

    logic [63:0] corners [12];

    initial begin
        corners[0]  = 64'h0000_0000_0000_0000;
        corners[1]  = 64'h8000_0000_0000_0000;
        corners[2]  = 64'h0000_0000_0000_0001;
        corners[3]  = 64'h800F_FFFF_FFFF_FFFF;
        corners[4]  = 64'h3FF0_0000_0000_0000;
        corners[5]  = 64'hC010_0000_0000_0001;
        corners[6]  = 64'h7FEF_FFFF_FFFF_FFFF;
        corners[7]  = 64'h0010_0000_0000_0000;
        corners[8]  = 64'h7FF0_0000_0000_0000;
        corners[9]  = 64'hFFF0_0000_0000_0000;
        corners[10] = 64'h7FF8_0000_0000_0000;
        corners[11] = 64'hFFF0_0000_0000_0001;

        repeat (3) @(negedge clk);
        op_in = 64'h7FF0_0000_0000_0000; mode_sel = 2'b00;
        @(negedge clk);
        n_tests++;  // R10 reset state
        if (op_out !== 64'd0 || trap_out !== 1'b0 || cause_out !== 2'b00) begin
            n_fail++;
            $display("FAIL R10 reset got v=%h t=%0d c=%0d exp v=0 t=0 c=0",
                     op_out, trap_out, cause_out);
        end
        rst = 1'b0;

        for (int m = 0; m < 4; m++)
            for (int d = 0; d < 2; d++)
                for (int k = 0; k < 12; k++)
                    apply(corners[k], d[0], m[1:0]);

        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] r;
            logic [2:0]  pick;
            r = {$urandom, $urandom};
            pick = 3'($urandom_range(0, 5));
            if (pick == 0) r[62:52] = 11'h000;
            else if (pick == 1) r[62:52] = 11'h7ff;
            else if (pick == 2) begin r[62:52] = 11'h7ff; r[51:0] = '0; end
            else if (pick == 3) begin r[62:52] = 11'h000; r[51:0] = '0; end
            apply(r, 1'($urandom), 2'($urandom));
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule